// File: doc/BRIEF.md
# Execute-Only Flash Region Filter

This block screens every access made to an embedded flash array against two protected windows whose contents may be executed but never observed. An access whose address falls inside either window is allowed only if it is a processor instruction fetch. A data load by the processor, a DMA transfer, a debugger access, a program (write) or an erase is refused. Accesses outside both windows are always allowed. Each response is registered and appears one clock after the access is presented. Each refusal also sets a sticky error flag, which software clears by writing a one to it.

The windows are described in page units by a first-page and last-page pair each. The meaning of a page depends on the bank-mode input. With a single bank, a page is 16 bytes counted from the start of the array, and either window may lie anywhere in the array. With two banks, the array splits into equal halves, a page is 8 bytes counted from the start of its half, and each window is tied to one half. The window registers can be written only while a configuration-unlock input is held high.

Top module: `xo_region_filter`

## Requirements
- R1: An access that falls in a window is granted only when `acc_kind` is 0 (instruction fetch). Kinds 1 (data read), 2 (DMA), 3 (debug), 4 (write), 5 (erase), and the unused codes 6 and 7, are denied. Every access outside both windows is granted.
- R2: With `dual_bank` low, byte offset `a` lies in window x when first_x ≤ a/16 ≤ last_x. Both windows cover the whole array.
- R3: With `dual_bank` high, address bit ADDR_W-1 selects the half. Window 1 matches only in the half where that bit is 0, and window 2 only where it is 1. The page is (low ADDR_W-1 bits)/8, and the same first ≤ page ≤ last rule applies.
- R4: When first equals last, the window is exactly one page: 16 bytes with one bank, 8 bytes with two. When last is below first, the window is empty and matches nothing.
- R5: An access presented at a clock edge is answered on `rsp_valid`, `rsp_grant`, `rsp_deny` and `rsp_hit` after that same edge. `rsp_hit[0]` reports window 1 and `rsp_hit[1]` reports window 2. A cycle with `acc_valid` low gives all response outputs zero in the next cycle.
- R6: A denied access sets `acc_err` in the same cycle that `rsp_deny` is shown. The flag holds until `err_clr` is high at a clock edge. If a denial arrives in that same cycle, the set wins.
- R7: `cfg_we` writes `cfg_wdata` only while `cfg_unlock` is high. `cfg_sel` selects the target: 0 is first page of window 1, 1 is last page of window 1, 2 is first page of window 2, and 3 is last page of window 2. A write made while locked changes nothing.
- R8: After reset, both windows are empty (first all ones, last zero), `acc_err` is clear, and all response outputs are zero.
- R9: Granted accesses never set `acc_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | ADDR_W | Byte offset of the access from the array start |
| acc_kind | input | 3 | Access type code (see R1) |
| dual_bank | input | 1 | 1: two-bank page layout, 0: single bank |
| cfg_unlock | input | 1 | Permits window register writes |
| cfg_we | input | 1 | Window register write strobe |
| cfg_sel | input | 2 | Window register select (see R7) |
| cfg_wdata | input | ADDR_W-4 | Page value to write |
| err_clr | input | 1 | Write-1-to-clear for the error flag |
| rsp_valid | output | 1 | Response for the access of the previous edge |
| rsp_grant | output | 1 | Access allowed |
| rsp_deny | output | 1 | Access refused |
| rsp_hit | output | 2 | Per-window match of that access |
| acc_err | output | 1 | Sticky access error flag |

## Verification
A wrong page boundary or a mis-stored window register shows up at once as a grant/deny flip on the very next response, but only for addresses right at a window edge. The bench therefore probes the byte just below each edge, the edge byte itself, the last byte inside, and the first byte past the end, with every access code, in both bank layouts. A half-select error in two-bank mode appears as a hit in the wrong half, so full-array sweeps with an 8-byte stride back up the edge probes. A corrupted error flag is visible one cycle after the access that should, or should not, have set it. For that reason the flag is compared after every access.

// File: rtl/xo_filter_pkg.sv
package xo_filter_pkg;

    typedef enum logic [2:0] {
        ACC_FETCH = 3'd0,
        ACC_DREAD = 3'd1,
        ACC_DMA   = 3'd2,
        ACC_DEBUG = 3'd3,
        ACC_WRITE = 3'd4,
        ACC_ERASE = 3'd5
    } acc_kind_e;

    typedef enum logic [1:0] {
        SEL_W1_FIRST = 2'd0,
        SEL_W1_LAST  = 2'd1,
        SEL_W2_FIRST = 2'd2,
        SEL_W2_LAST  = 2'd3
    } cfg_sel_e;

    localparam int NUM_WIN = 2;

    // Only a CPU instruction fetch may enter a protected window.
    function automatic logic kind_may_enter(input logic [2:0] kind);
        return kind == ACC_FETCH;
    endfunction

endpackage

// File: rtl/xo_window_regs.sv
module xo_window_regs #(
    parameter int PG_W    = 16,
    parameter int NUM_WIN = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_unlock,
    input  logic                              cfg_we,
    input  logic [$clog2(2*NUM_WIN)-1:0]      cfg_sel,
    input  logic [PG_W-1:0]                   cfg_wdata,
    output logic [NUM_WIN-1:0][PG_W-1:0]      pg_first,
    output logic [NUM_WIN-1:0][PG_W-1:0]      pg_last
);
    localparam int SEL_W = $clog2(2*NUM_WIN);

    typedef struct packed {
        logic [NUM_WIN-1:0][PG_W-1:0] first;
        logic [NUM_WIN-1:0][PG_W-1:0] last;
    } win_cfg_t;

    win_cfg_t cfg_d, cfg_q;

    // R7: writes land only while unlocked; odd select = last page
    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we && cfg_unlock) begin
            if (cfg_sel[0]) begin
                cfg_d.last[cfg_sel[SEL_W-1:1]] = cfg_wdata;
            end else begin
                cfg_d.first[cfg_sel[SEL_W-1:1]] = cfg_wdata;
            end
        end
    end

    // R8: reset leaves every window empty (first above last)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.first <= '1;
            cfg_q.last  <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign pg_first = cfg_q.first;
    assign pg_last  = cfg_q.last;

endmodule

// File: rtl/xo_window_match.sv
module xo_window_match #(
    parameter int ADDR_W = 20,
    parameter int WIN_ID = 0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              dual_bank,
    input  logic [ADDR_W-5:0] pg_first,
    input  logic [ADDR_W-5:0] pg_last,
    output logic              hit
);
    localparam logic OWN_HALF = (WIN_ID != 0);

    logic [ADDR_W-5:0] page;
    logic              in_half;
    logic              nonempty;

    always_comb begin
        if (dual_bank) begin
            // R3: 8-byte pages from the base of this window's half
            page    = addr[ADDR_W-2:3];
            in_half = (addr[ADDR_W-1] == OWN_HALF);
        end else begin
            // R2: 16-byte pages from the array base
            page    = addr[ADDR_W-1:4];
            in_half = 1'b1;
        end
        // R4: last below first means empty
        nonempty = (pg_first <= pg_last);
        hit      = in_half && nonempty && (page >= pg_first) && (page <= pg_last);
    end

endmodule

// File: rtl/xo_access_judge.sv
module xo_access_judge
    import xo_filter_pkg::*;
#(
    parameter int NUM_WIN = 2
) (
    input  logic               acc_valid,
    input  logic [2:0]         acc_kind,
    input  logic [NUM_WIN-1:0] win_hit,
    output logic               grant,
    output logic               deny
);
    logic protected_hit;

    // R1: inside a window only fetches pass; outside everything passes
    always_comb begin
        protected_hit = |win_hit;
        deny  = acc_valid && protected_hit && !kind_may_enter(acc_kind);
        grant = acc_valid && !deny;
    end

endmodule

// File: rtl/xo_region_filter.sv
module xo_region_filter
    import xo_filter_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [2:0]        acc_kind,
    input  logic              dual_bank,
    input  logic              cfg_unlock,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-5:0] cfg_wdata,
    input  logic              err_clr,
    output logic              rsp_valid,
    output logic              rsp_grant,
    output logic              rsp_deny,
    output logic [1:0]        rsp_hit,
    output logic              acc_err
);
    localparam int PG_W = ADDR_W - 4;

    logic [NUM_WIN-1:0][PG_W-1:0] pg_first;
    logic [NUM_WIN-1:0][PG_W-1:0] pg_last;
    logic [NUM_WIN-1:0]           win_hit;
    logic                         judge_grant;
    logic                         judge_deny;

    typedef struct packed {
        logic               vld;
        logic               grant;
        logic               deny;
        logic [NUM_WIN-1:0] hit;
        logic               err;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    xo_window_regs #(
        .PG_W    (PG_W),
        .NUM_WIN (NUM_WIN)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_unlock (cfg_unlock),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .pg_first   (pg_first),
        .pg_last    (pg_last)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        xo_window_match #(
            .ADDR_W (ADDR_W),
            .WIN_ID (w)
        ) u_match (
            .addr      (acc_addr),
            .dual_bank (dual_bank),
            .pg_first  (pg_first[w]),
            .pg_last   (pg_last[w]),
            .hit       (win_hit[w])
        );
    end

    xo_access_judge #(
        .NUM_WIN (NUM_WIN)
    ) u_judge (
        .acc_valid (acc_valid),
        .acc_kind  (acc_kind),
        .win_hit   (win_hit),
        .grant     (judge_grant),
        .deny      (judge_deny)
    );

    always_comb begin
        rsp_d.vld   = acc_valid;
        rsp_d.grant = judge_grant;
        rsp_d.deny  = judge_deny;
        rsp_d.hit   = acc_valid ? win_hit : '0;
        // R6: set has priority over the write-1-to-clear
        rsp_d.err   = (rsp_q.err && !err_clr) || judge_deny;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.vld;
    assign rsp_grant = rsp_q.grant;
    assign rsp_deny  = rsp_q.deny;
    assign rsp_hit   = rsp_q.hit;
    assign acc_err   = rsp_q.err;

endmodule

// File: rtl/xo_region_filter_chk.sv
module xo_region_filter_chk #(
    parameter int PG_W = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 acc_valid,
    input logic [2:0]           acc_kind,
    input logic                 dual_bank,
    input logic                 cfg_unlock,
    input logic                 cfg_we,
    input logic                 err_clr,
    input logic                 rsp_valid,
    input logic                 rsp_grant,
    input logic                 rsp_deny,
    input logic [1:0]           rsp_hit,
    input logic                 acc_err,
    input logic [1:0][PG_W-1:0] pg_first,
    input logic [1:0][PG_W-1:0] pg_last
);
    a_r1_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_grant ^ rsp_deny));

    a_r1_fetch_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_kind == 3'd0) |=> rsp_grant);

    a_r1_deny_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_deny |-> (rsp_hit != 2'b00));

    a_r3_single_half: assert property (@(posedge clk) disable iff (!rst_n)
        dual_bank |=> $onehot0(rsp_hit));

    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (!rsp_valid && !rsp_grant && !rsp_deny && rsp_hit == 2'b00));

    a_r6_deny_sets: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_deny |-> acc_err);

    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_err && !err_clr) |=> acc_err);

    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr |=> (acc_err == rsp_deny));

    a_r9_rise_only_on_deny: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acc_err) |-> rsp_deny);

    a_r7_locked_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_unlock) |=> ($stable(pg_first) && $stable(pg_last)));

endmodule

bind xo_region_filter xo_region_filter_chk #(
    .PG_W (PG_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_kind   (acc_kind),
    .dual_bank  (dual_bank),
    .cfg_unlock (cfg_unlock),
    .cfg_we     (cfg_we),
    .err_clr    (err_clr),
    .rsp_valid  (rsp_valid),
    .rsp_grant  (rsp_grant),
    .rsp_deny   (rsp_deny),
    .rsp_hit    (rsp_hit),
    .acc_err    (acc_err),
    .pg_first   (pg_first),
    .pg_last    (pg_last)
);

// File: tb/xo_region_filter_bench.sv
`timescale 1ns/1ps
module xo_region_filter_bench;
    localparam int AW = 10;
    localparam int PW = AW - 4;
    localparam int NB = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          acc_valid;
    logic [AW-1:0] acc_addr;
    logic [2:0]    acc_kind;
    logic          dual_bank;
    logic          cfg_unlock;
    logic          cfg_we;
    logic [1:0]    cfg_sel;
    logic [PW-1:0] cfg_wdata;
    logic          err_clr;
    logic          rsp_valid, rsp_grant, rsp_deny, acc_err;
    logic [1:0]    rsp_hit;

    int  n_chk = 0;
    int  n_bad = 0;
    int  m_first [2];
    int  m_last  [2];
    bit  m_err;
    bit  done = 0;

    always #2.5 clk = ~clk;

    xo_region_filter #(.ADDR_W(AW)) u_xo_region_filter (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_kind(acc_kind), .dual_bank(dual_bank), .cfg_unlock(cfg_unlock),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .err_clr(err_clr),
        .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_deny(rsp_deny),
        .rsp_hit(rsp_hit), .acc_err(acc_err)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int m_hit(input int a, input bit dual);
        int h = 0;
        for (int r = 0; r < 2; r++) begin
            int pg;
            bit inh;
            if (dual) begin
                pg  = (a % (NB / 2)) / 8;
                inh = ((a / (NB / 2)) == r);
            end else begin
                pg  = a / 16;
                inh = 1'b1;
            end
            if (inh && m_first[r] <= m_last[r] && pg >= m_first[r] && pg <= m_last[r])
                h |= (1 << r);
        end
        return h;
    endfunction

    // response code: valid*16 + grant*8 + deny*4 + hit
    task automatic access(input int a, input int k, input string tag);
        int eh, ed;
        acc_addr  = a[AW-1:0];
        acc_kind  = k[2:0];
        acc_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        acc_valid = 1'b0;
        eh = m_hit(a, dual_bank);
        ed = (eh != 0 && k != 0) ? 1 : 0;
        if (ed != 0) m_err = 1'b1;
        check(tag, $sformatf("rsp addr=%0d kind=%0d", a, k),
              rsp_valid * 16 + rsp_grant * 8 + rsp_deny * 4 + rsp_hit,
              16 + (1 - ed) * 8 + ed * 4 + eh);
        check("R6/R9", "acc_err", acc_err, m_err);
    endtask

    task automatic cfg_write(input int sel, input int val, input bit unl);
        cfg_sel    = sel[1:0];
        cfg_wdata  = val[PW-1:0];
        cfg_unlock = unl;
        cfg_we     = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cfg_we     = 1'b0;
        cfg_unlock = 1'b0;
        if (unl) begin
            if (sel % 2 == 1) m_last[sel / 2] = val;
            else              m_first[sel / 2] = val;
        end
    endtask

    task automatic clear_err();
        err_clr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        err_clr = 1'b0;
        m_err   = 1'b0;
        check("R6", "acc_err after clear", acc_err, 0);
    endtask

    task automatic edges(input int r, input string tag);
        int g, base, lo, hi;
        int pts [4];
        g    = dual_bank ? 8 : 16;
        base = dual_bank ? r * (NB / 2) : 0;
        lo   = base + m_first[r] * g;
        hi   = base + (m_last[r] + 1) * g - 1;
        pts  = '{lo - 1, lo, hi, hi + 1};
        for (int p = 0; p < 4; p++)
            if (pts[p] >= 0 && pts[p] < NB)
                for (int k = 0; k < 8; k++) access(pts[p], k, tag);
    endtask

    task automatic sweep(input string tag);
        for (int a = 0; a < NB; a += 8)
            for (int k = 0; k < 8; k++) access(a, k, tag);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 190000) begin
                n_bad++;
                n_chk++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
                $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
                $finish;
            end
        end
    end

    initial begin
        rst_n = 1'b0; acc_valid = 1'b0; acc_addr = '0; acc_kind = '0;
        dual_bank = 1'b0; cfg_unlock = 1'b0; cfg_we = 1'b0; cfg_sel = '0;
        cfg_wdata = '0; err_clr = 1'b0; m_err = 1'b0;
        m_first = '{63, 63};
        m_last  = '{0, 0};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        check("R8", "reset outputs",
              rsp_valid * 16 + rsp_grant * 8 + rsp_deny * 4 + rsp_hit + acc_err * 32, 0);
        sweep("R8");

        // R7: locked write ignored, then the target address still passes
        cfg_write(0, 3, 1'b0);
        cfg_write(1, 5, 1'b0);
        access(48, 1, "R7");

        // single bank: window 1 pages 3..5, window 2 one page 40
        cfg_write(0, 3, 1'b1);
        cfg_write(1, 5, 1'b1);
        cfg_write(2, 40, 1'b1);
        cfg_write(3, 40, 1'b1);
        edges(0, "R2");
        edges(1, "R4");
        sweep("R1");
        clear_err();
        cfg_write(1, 63, 1'b0);
        edges(0, "R7");

        // dual bank: window 1 pages 10..12, window 2 pages 60..63 (top of array)
        dual_bank = 1'b1;
        cfg_write(0, 10, 1'b1);
        cfg_write(1, 12, 1'b1);
        cfg_write(2, 60, 1'b1);
        cfg_write(3, 63, 1'b1);
        edges(0, "R3");
        edges(1, "R3");
        sweep("R3");
        clear_err();

        // single page in dual mode, then an empty window
        cfg_write(0, 7, 1'b1);
        cfg_write(1, 7, 1'b1);
        edges(0, "R4");
        cfg_write(0, 20, 1'b1);
        cfg_write(1, 12, 1'b1);
        sweep("R4");
        clear_err();

        // R6: a denial in the clear cycle wins
        acc_addr = 10'd992; acc_kind = 3'd1; acc_valid = 1'b1; err_clr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        acc_valid = 1'b0; err_clr = 1'b0; m_err = 1'b1;
        check("R6", "set beats clear", acc_err, 1);
        access(992, 0, "R9");
        clear_err();
        access(0, 4, "R9");

        // R5: idle cycle gives a quiet response
        @(posedge clk);
        @(negedge clk);
        check("R5", "idle response",
              rsp_valid * 16 + rsp_grant * 8 + rsp_deny * 4 + rsp_hit, 0);

        done = 1'b1;
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule